// File: doc/BRIEF.md
# Maskable Event Interrupt Unit

This block gathers single-cycle event pulses from five sources: two transfer channels reporting completion, a 1 ms frame-start timer tick, a device attach/detach detector and a shared device-detect/resume detector. Each pulse sets a bit in a status register. The CPU can poll that register at any time, whatever the enable register holds, and it clears a bit by writing a 1 to that bit.

An 8-bit enable register holds one enable for each status bit. The single interrupt request output is the OR, over all bits, of status AND enable. It comes from a flip-flop so that it cannot glitch. The frame-timer event is latched only while a separate timer-run control input is high. Bit 6 is shared by two events: the suspend input decides whether it takes the resume event (suspended) or the device-detect event (running).

Top module: `intr_event_ctrl`

## Requirements
- R1: After reset, the enable register, the status register and `irq` all read 0.
- R2: A cycle with `en_wr` high loads `en_wdata` into the enable register. The new value appears on `en_rdata` after that clock edge, with bits 2, 3 and 7 forced to 0.
- R3: An event pulse sets its status bit at the next clock edge whatever the enable register holds. The bit positions are: channel A done = 0, channel B done = 1, timer tick = 4, attach/detach = 5, detect/resume = 6.
- R4: `sof_tick` sets status bit 4 only in a cycle where `sof_run` is 1. A tick while `sof_run` is 0 leaves the bit unchanged.
- R5: While `suspend` is 1, `resume_evt` sets status bit 6 and `detect_evt` has no effect. While `suspend` is 0, `detect_evt` sets bit 6 and `resume_evt` has no effect.
- R6: A cycle with `stat_clr` high clears every status bit whose bit in `stat_clr_mask` is 1. Bits whose mask bit is 0 keep their value.
- R7: If an event and a clear of the same status bit arrive in the same cycle, the bit stays set.
- R8: `irq` equals the OR of (status AND enable) as it stood one clock earlier. This makes `irq` one cycle later than the register values that cause it.
- R9: Status bits 2, 3 and 7 always read 0. Writes and clears leave them at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_a_evt | input | 1 | Channel A transfer-done pulse |
| done_b_evt | input | 1 | Channel B transfer-done pulse |
| sof_tick | input | 1 | 1 ms frame-timer tick pulse |
| sof_run | input | 1 | Frame-timer enable control level |
| attach_evt | input | 1 | Device attach/detach pulse |
| detect_evt | input | 1 | Device-detect pulse (used while not suspended) |
| resume_evt | input | 1 | Resume pulse (used while suspended) |
| suspend | input | 1 | Suspend state level; selects the bit 6 source |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register contents |
| stat_clr | input | 1 | Status write-1-to-clear strobe |
| stat_clr_mask | input | 8 | Status bits to clear |
| stat_rdata | output | 8 | Status register contents |
| irq | output | 1 | Registered interrupt request |

## Verification
Status bits and enable bits change on the clock edge that samples their stimulus. `irq` changes one edge after that. The bench drives every input just after a falling edge and samples at the next falling edge. At each sample it compares the registers with a model that it advanced for the same edge. It compares `irq` with the status AND enable value the model held before that edge, so the one-cycle lag of R8 is checked on every cycle. The sweeps cover all 256 enable words and all 256 clear masks against a fully set status register, every event source, both suspend states and the same-cycle event/clear collision.

// File: rtl/intr_event_pkg.sv
// Package: shared widths, bit positions and the writable-bit mask for the
// event interrupt unit. Assumes an 8-bit register layout.
package intr_event_pkg;
    localparam int IRQ_W = 8;
    localparam int B_DONE_A = 0;
    localparam int B_DONE_B = 1;
    localparam int B_SOF    = 4;
    localparam int B_ATTACH = 5;
    localparam int B_DETRES = 6;

    typedef logic [IRQ_W-1:0] irq_vec_t;

    localparam irq_vec_t WR_MASK = irq_vec_t'((1 << B_DONE_A) | (1 << B_DONE_B) |
                                              (1 << B_SOF) | (1 << B_ATTACH) |
                                              (1 << B_DETRES));
endpackage

// File: rtl/intr_src_map.sv
// Module: maps raw event pulses onto a status-set vector.
// Assumes events are single-cycle pulses in the clk domain. Gates the timer
// tick with its run control and picks the bit 6 source by suspend state.
module intr_src_map
    import intr_event_pkg::*;
(
    input  logic     done_a_evt,
    input  logic     done_b_evt,
    input  logic     sof_tick,
    input  logic     sof_run,
    input  logic     attach_evt,
    input  logic     detect_evt,
    input  logic     resume_evt,
    input  logic     suspend,
    output irq_vec_t set_vec
);
    // Build the set vector; reserved positions stay 0.
    always_comb begin
        set_vec           = '0;
        set_vec[B_DONE_A] = done_a_evt;
        set_vec[B_DONE_B] = done_b_evt;
        set_vec[B_SOF]    = sof_tick & sof_run;
        set_vec[B_ATTACH] = attach_evt;
        set_vec[B_DETRES] = suspend ? resume_evt : detect_evt;
    end
endmodule

// File: rtl/intr_en_reg.sv
// Module: enable register. Loads on a write strobe; positions outside
// WR_MASK are held at 0. Synchronous active-low reset.
module intr_en_reg
    import intr_event_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  irq_vec_t wdata,
    output irq_vec_t en_q
);
    // Hold or load the enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (wr) en_q <= wdata & WR_MASK;
    end
endmodule

// File: rtl/intr_stat_reg.sv
// Module: status register with set-on-event and write-1-to-clear.
// Assumes set and clear may coincide; set has priority. Reserved bits are
// held at 0. Synchronous active-low reset.
module intr_stat_reg
    import intr_event_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t set_vec,
    input  logic     clr,
    input  irq_vec_t clr_mask,
    output irq_vec_t st_q
);
    irq_vec_t clr_vec;
    irq_vec_t nxt;

    // Compute the next status: clear first, then OR in the new events.
    always_comb begin
        clr_vec = clr ? clr_mask : '0;
        nxt     = (st_q & ~clr_vec) | set_vec;
    end

    // Register each bit; reserved positions stay 0.
    always_ff @(posedge clk) begin
        for (int i = 0; i < IRQ_W; i++) begin
            if (!rst_n || !WR_MASK[i]) st_q[i] <= 1'b0;
            else                       st_q[i] <= nxt[i];
        end
    end
endmodule

// File: rtl/intr_req_gen.sv
// Module: glitch-free interrupt request. Registers the OR of status AND
// enable. Synchronous active-low reset.
module intr_req_gen
    import intr_event_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t st,
    input  irq_vec_t en,
    output logic     irq
);
    // Register the masked OR.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(st & en);
    end
endmodule

// File: rtl/intr_event_ctrl.sv
// Module: top of the maskable event interrupt unit. Combines source mapping,
// enable and status registers and the registered request. Assumes all
// inputs are synchronous to clk.
module intr_event_ctrl
    import intr_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_a_evt,
    input  logic             done_b_evt,
    input  logic             sof_tick,
    input  logic             sof_run,
    input  logic             attach_evt,
    input  logic             detect_evt,
    input  logic             resume_evt,
    input  logic             suspend,
    input  logic             en_wr,
    input  logic [IRQ_W-1:0] en_wdata,
    output logic [IRQ_W-1:0] en_rdata,
    input  logic             stat_clr,
    input  logic [IRQ_W-1:0] stat_clr_mask,
    output logic [IRQ_W-1:0] stat_rdata,
    output logic             irq
);
    irq_vec_t set_vec;
    irq_vec_t en_q;
    irq_vec_t st_q;

    intr_src_map u_map (
        .done_a_evt (done_a_evt),
        .done_b_evt (done_b_evt),
        .sof_tick   (sof_tick),
        .sof_run    (sof_run),
        .attach_evt (attach_evt),
        .detect_evt (detect_evt),
        .resume_evt (resume_evt),
        .suspend    (suspend),
        .set_vec    (set_vec)
    );

    intr_en_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .en_q  (en_q)
    );

    intr_stat_reg u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr      (stat_clr),
        .clr_mask (stat_clr_mask),
        .st_q     (st_q)
    );

    intr_req_gen u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .st    (st_q),
        .en    (en_q),
        .irq   (irq)
    );

    assign en_rdata   = en_q;
    assign stat_rdata = st_q;
endmodule

// File: rtl/intr_event_ctrl_chk.sv
// Module: assertion checker for intr_event_ctrl, attached by bind below.
// Watches ports only.
module intr_event_ctrl_chk
    import intr_event_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             done_a_evt,
    input logic             done_b_evt,
    input logic             sof_tick,
    input logic             sof_run,
    input logic             attach_evt,
    input logic             detect_evt,
    input logic             resume_evt,
    input logic             suspend,
    input logic             en_wr,
    input logic [IRQ_W-1:0] en_wdata,
    input logic [IRQ_W-1:0] en_rdata,
    input logic             stat_clr,
    input logic [IRQ_W-1:0] stat_clr_mask,
    input logic [IRQ_W-1:0] stat_rdata,
    input logic             irq
);
    p_reset_r1: assert property (@(posedge clk) !rst_n |=> (en_rdata == '0 && stat_rdata == '0 && !irq));

    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> en_rdata == ($past(en_wdata) & WR_MASK));

    p_done_a_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_a_evt |=> stat_rdata[B_DONE_A]);

    p_attach_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        attach_evt |=> stat_rdata[B_ATTACH]);

    p_sof_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_run && !stat_rdata[B_SOF]) |=> !stat_rdata[B_SOF]);

    p_resume_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && resume_evt) |=> stat_rdata[B_DETRES]);

    p_detect_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && detect_evt) |=> stat_rdata[B_DETRES]);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && stat_clr_mask[B_DONE_B] && !done_b_evt) |=> !stat_rdata[B_DONE_B]);

    p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && stat_clr_mask[B_DONE_A] && done_a_evt) |=> stat_rdata[B_DONE_A]);

    p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(stat_rdata & en_rdata)));

    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rdata | en_rdata) & ~WR_MASK) == '0);
endmodule

bind intr_event_ctrl intr_event_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done_a_evt    (done_a_evt),
    .done_b_evt    (done_b_evt),
    .sof_tick      (sof_tick),
    .sof_run       (sof_run),
    .attach_evt    (attach_evt),
    .detect_evt    (detect_evt),
    .resume_evt    (resume_evt),
    .suspend       (suspend),
    .en_wr         (en_wr),
    .en_wdata      (en_wdata),
    .en_rdata      (en_rdata),
    .stat_clr      (stat_clr),
    .stat_clr_mask (stat_clr_mask),
    .stat_rdata    (stat_rdata),
    .irq           (irq)
);

// File: tb/tb_intr_event_ctrl.sv
module tb_intr_event_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] WMASK = 8'h73;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_a_evt = 0, done_b_evt = 0, sof_tick = 0, sof_run = 0;
    logic attach_evt = 0, detect_evt = 0, resume_evt = 0, suspend = 0;
    logic en_wr = 0, stat_clr = 0;
    logic [7:0] en_wdata = '0, stat_clr_mask = '0;
    logic [7:0] en_rdata, stat_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_en = '0, m_st = '0;
    logic m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_event_ctrl dut (
        .clk (clk), .rst_n (rst_n),
        .done_a_evt (done_a_evt), .done_b_evt (done_b_evt),
        .sof_tick (sof_tick), .sof_run (sof_run),
        .attach_evt (attach_evt), .detect_evt (detect_evt),
        .resume_evt (resume_evt), .suspend (suspend),
        .en_wr (en_wr), .en_wdata (en_wdata), .en_rdata (en_rdata),
        .stat_clr (stat_clr), .stat_clr_mask (stat_clr_mask),
        .stat_rdata (stat_rdata), .irq (irq)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Advance the model by one edge, clock the DUT, compare, drop the pulses.
    task automatic step(string req);
        logic [7:0] setv;
        logic [7:0] clrv;
        setv = '0;
        setv[0] = done_a_evt;
        setv[1] = done_b_evt;
        setv[4] = sof_tick & sof_run;
        setv[5] = attach_evt;
        setv[6] = suspend ? resume_evt : detect_evt;
        clrv = stat_clr ? stat_clr_mask : 8'h00;
        m_irq = |(m_st & m_en);
        m_st  = ((m_st & ~clrv) | setv) & WMASK;
        if (en_wr) m_en = en_wdata & WMASK;
        @(negedge clk);
        check(req, "en_rdata", en_rdata, m_en);
        check(req, "stat_rdata", stat_rdata, m_st);
        check(req, "irq", {7'b0, irq}, {7'b0, m_irq});
        done_a_evt = 0; done_b_evt = 0; sof_tick = 0; attach_evt = 0;
        detect_evt = 0; resume_evt = 0; en_wr = 0; stat_clr = 0;
    endtask

    task automatic fire_all();
        done_a_evt = 1; done_b_evt = 1; sof_run = 1; sof_tick = 1;
        attach_evt = 1; detect_evt = 1; suspend = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "en_rdata", en_rdata, 8'h00);
        check("R1", "stat_rdata", stat_rdata, 8'h00);
        check("R1", "irq", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        step("R1");

        // R3: each source alone sets its bit with enables all 0
        for (int s = 0; s < 5; s++) begin
            case (s)
                0: done_a_evt = 1;
                1: done_b_evt = 1;
                2: begin sof_run = 1; sof_tick = 1; end
                3: attach_evt = 1;
                default: detect_evt = 1;
            endcase
            step("R3");
            step("R3");
            stat_clr = 1; stat_clr_mask = 8'hFF;
            step("R6");
        end

        // R4: tick with run low is ignored, with run high it sets bit 4
        sof_run = 0; sof_tick = 1; step("R4");
        step("R4");
        sof_run = 1; sof_tick = 1; step("R4");
        stat_clr = 1; stat_clr_mask = 8'h10; step("R4");

        // R5: bit 6 source by suspend state, all four combinations
        for (int sp = 0; sp < 2; sp++) begin
            for (int ev = 0; ev < 2; ev++) begin
                suspend = sp[0];
                if (ev == 0) detect_evt = 1; else resume_evt = 1;
                step("R5");
                stat_clr = 1; stat_clr_mask = 8'h40; step("R5");
            end
        end
        suspend = 0;

        // R2, R8, R9: all enable words against a full status register
        fire_all(); step("R3");
        for (int e = 0; e < 256; e++) begin
            en_wr = 1; en_wdata = 8'(e); step("R2");
            step("R8");
            step("R9");
        end

        // R6, R9: every clear mask on a full status register, enables all set
        en_wr = 1; en_wdata = 8'hFF; step("R2");
        for (int m = 0; m < 256; m++) begin
            fire_all(); step("R3");
            stat_clr = 1; stat_clr_mask = 8'(m); step("R6");
            step("R8");
        end

        // R7: event and clear of the same bit in one cycle
        stat_clr = 1; stat_clr_mask = 8'hFF; step("R6");
        fire_all(); stat_clr = 1; stat_clr_mask = 8'hFF; step("R7");
        step("R7");
        suspend = 1; resume_evt = 1; stat_clr = 1; stat_clr_mask = 8'h40; step("R7");
        suspend = 0;

        // R8: irq drops one cycle after the last enabled bit clears
        stat_clr = 1; stat_clr_mask = 8'hFF; step("R8");
        step("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule